// File: doc/BRIEF.md
# Reset-Vector Branch Instruction Slave

This block is a read-only slave on a processor's local bus. It claims the topmost 256 bytes of a 32-bit address map. That window holds the address of the processor's first instruction fetch after reset, 0xFFFFFFFC. Whatever word is read from the window, the slave returns the same 32-bit instruction, 0x4BFF7FE4. This is a relative branch that sends a fetch at 0xFFFFFFFC to 0xFFFF7FE0, where a boot section in on-chip memory begins. Because of this, no memory is needed at the reset vector.

The processor's instruction side reads non-cacheable space as four-word cacheline transfers, and it reads cacheable space as eight-word lines. Its data side reads single words. The requester waits until every word of a line has arrived, and it uses a per-beat word-address tag to place each word. So the slave must sequence that tag correctly and finish every beat, or the fetch from reset never completes. After a one-cycle address acknowledge, the slave streams one beat per cycle and marks the last beat with a completion pulse. Writes into the window are acknowledged and have no effect. While a transfer is in progress, new requests are not taken.

Top module: `rvb_reset_branch_slave`

## Requirements
- R1: While reset is held, addr_ack, wr_done, rd_valid and rd_done are low, and rd_data and rd_tag are zero.
- R2: A request is accepted only when req_addr[31:8] equals 0xFFFFFF. A request outside that window gets no addr_ack and no data beats.
- R3: An accepted request (req_valid high on a clock edge while the slave is free) raises addr_ack for exactly one cycle, in the cycle after that edge.
- R4: On every read beat, rd_data is 0x4BFF7FE4 with byte 0x4B on bits 31:24 (big-endian). rd_data is zero when rd_valid is low.
- R5: req_size 2'b00 is a single-word read. It produces one beat whose rd_tag equals req_addr[4:2], with rd_done set on that beat.
- R6: req_size 2'b01 is a four-word line read. It produces four beats with rd_tag 0, 1, 2, 3 in that order, whatever the low address bits are.
- R7: req_size 2'b10 is an eight-word line read. It produces eight beats with rd_tag 0 through 7 in order. The code 2'b11 is handled as a single-word read.
- R8: rd_done is high on the last beat of a read and on no other cycle.
- R9: An accepted write (req_rnw low) raises wr_done in the same cycle as addr_ack and produces no read beats. Later reads are unchanged.
- R10: From the acknowledge of a read until its last beat, the slave ignores requests and raises no addr_ack.
- R11: Read beats begin in the cycle after addr_ack and occupy consecutive cycles, with no gaps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present on the address lines |
| req_addr | input | 32 | Request byte address |
| req_rnw | input | 1 | 1 = read, 0 = write |
| req_size | input | 2 | 00 single, 01 four-word line, 10 eight-word line, 11 single |
| addr_ack | output | 1 | One-cycle address acknowledge |
| wr_done | output | 1 | Write completion, with addr_ack |
| rd_valid | output | 1 | Read data beat valid |
| rd_data | output | 32 | Read data (fixed branch instruction) |
| rd_tag | output | 3 | Word-address tag of the current beat |
| rd_done | output | 1 | Read complete, on the last beat |

## Verification
The bound checker checks, on every cycle, the rules that hold locally in time. These are: addr_ack is a single-cycle pulse that follows a decoded request, every beat carries the constant, rd_done never appears without a beat, wr_done never appears without addr_ack, the tag steps by one between consecutive beats of a line, and no acknowledge overlaps a data phase. The end-to-end properties can only be shown by the bench's scenarios. These include the exact number of beats for each size code, a tag sequence that starts at zero for unaligned line addresses, the single-word tag taken from the address, and the fact that writes and out-of-window requests leave later reads unchanged.

// File: rtl/rvb_pkg.sv
package rvb_pkg;

  localparam int TAG_W = 3;
  localparam int CNT_W = 3;

  typedef enum logic [1:0] {
    XFER_SINGLE = 2'b00,
    XFER_LINE4  = 2'b01,
    XFER_LINE8  = 2'b10,
    XFER_RSVD   = 2'b11
  } xfer_size_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ACK  = 2'd1,
    PH_DATA = 2'd2
  } phase_e;

  // number of data beats minus one for a size code
  function automatic logic [CNT_W-1:0] last_beat_index(input logic [1:0] size);
    case (xfer_size_e'(size))
      XFER_LINE4: return CNT_W'(3);
      XFER_LINE8: return CNT_W'(7);
      default:    return CNT_W'(0);
    endcase
  endfunction

  // tag of the first beat: line reads start at the line base
  function automatic logic [TAG_W-1:0] start_tag(input logic [1:0] size,
                                                 input logic [TAG_W-1:0] word_idx);
    case (xfer_size_e'(size))
      XFER_LINE4, XFER_LINE8: return '0;
      default:                return word_idx;
    endcase
  endfunction

endpackage

// File: rtl/rvb_decode.sv
module rvb_decode #(
  parameter int          ADDR_W      = 32,
  parameter int          WINDOW_BITS = 8,
  parameter logic [31:0] WINDOW_BASE = 32'hFFFF_FF00
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam int TOP_W = ADDR_W - WINDOW_BITS;

  logic [TOP_W-1:0] addr_top;
  logic [TOP_W-1:0] base_top;

  assign addr_top = addr[ADDR_W-1:WINDOW_BITS];
  assign base_top = WINDOW_BASE[ADDR_W-1:WINDOW_BITS];
  assign hit      = (addr_top == base_top);
endmodule

// File: rtl/rvb_sequencer.sv
module rvb_sequencer
  import rvb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             acc_rnw,
  input  logic [1:0]       acc_size,
  input  logic [TAG_W-1:0] acc_word,
  output logic             idle,
  output logic             ack_phase,
  output logic             write_phase,
  output logic             beat_valid,
  output logic             beat_last,
  output logic [TAG_W-1:0] beat_tag
);
  phase_e           phase_q;
  logic             is_read_q;
  logic [CNT_W-1:0] remain_q;
  logic [TAG_W-1:0] tag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      is_read_q <= 1'b0;
      remain_q  <= '0;
      tag_q     <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          if (accept) begin
            phase_q   <= PH_ACK;
            is_read_q <= acc_rnw;
            remain_q  <= last_beat_index(acc_size);
            tag_q     <= start_tag(acc_size, acc_word);
          end
        end
        PH_ACK: begin
          phase_q <= is_read_q ? PH_DATA : PH_IDLE;
        end
        PH_DATA: begin
          if (remain_q == '0) begin
            phase_q <= PH_IDLE;
            tag_q   <= '0;
          end else begin
            remain_q <= remain_q - CNT_W'(1);
            tag_q    <= tag_q + TAG_W'(1);
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign idle        = (phase_q == PH_IDLE);
  assign ack_phase   = (phase_q == PH_ACK);
  assign write_phase = ack_phase && !is_read_q;
  assign beat_valid  = (phase_q == PH_DATA);
  assign beat_last   = beat_valid && (remain_q == '0);
  assign beat_tag    = beat_valid ? tag_q : '0;
endmodule

// File: rtl/rvb_beat_data.sv
module rvb_beat_data #(
  parameter int                DATA_W     = 32,
  parameter logic [DATA_W-1:0] INSN       = 32'h4BFF_7FE4,
  parameter bit                SWAP_BYTES = 1'b0
) (
  input  logic              beat_valid,
  output logic [DATA_W-1:0] data
);
  localparam int NBYTES = DATA_W / 8;

  logic [DATA_W-1:0] ordered;

  generate
    if (SWAP_BYTES) begin : g_swap
      for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        assign ordered[8*b +: 8] = INSN[8*(NBYTES-1-b) +: 8];
      end
    end else begin : g_keep
      assign ordered = INSN;
    end
  endgenerate

  assign data = beat_valid ? ordered : '0;
endmodule

// File: rtl/rvb_reset_branch_slave.sv
module rvb_reset_branch_slave
  import rvb_pkg::*;
#(
  parameter int          ADDR_W      = 32,
  parameter int          DATA_W      = 32,
  parameter int          WINDOW_BITS = 8,
  parameter logic [31:0] WINDOW_BASE = 32'hFFFF_FF00,
  parameter logic [31:0] BRANCH_WORD = 32'h4BFF_7FE4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_rnw,
  input  logic [1:0]        req_size,
  output logic              addr_ack,
  output logic              wr_done,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [TAG_W-1:0]  rd_tag,
  output logic              rd_done
);
  localparam int WORD_LSB = $clog2(DATA_W / 8);

  // named internal events for the checker
  logic             addr_hit;
  logic             slave_idle;
  logic             accept_evt;
  logic [TAG_W-1:0] req_word;

  rvb_decode #(
    .ADDR_W      (ADDR_W),
    .WINDOW_BITS (WINDOW_BITS),
    .WINDOW_BASE (WINDOW_BASE)
  ) u_decode (
    .addr (req_addr),
    .hit  (addr_hit)
  );

  assign req_word   = req_addr[WORD_LSB +: TAG_W];
  assign accept_evt = req_valid && addr_hit && slave_idle;

  rvb_sequencer u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept_evt),
    .acc_rnw     (req_rnw),
    .acc_size    (req_size),
    .acc_word    (req_word),
    .idle        (slave_idle),
    .ack_phase   (addr_ack),
    .write_phase (wr_done),
    .beat_valid  (rd_valid),
    .beat_last   (rd_done),
    .beat_tag    (rd_tag)
  );

  rvb_beat_data #(
    .DATA_W     (DATA_W),
    .INSN       (BRANCH_WORD[DATA_W-1:0]),
    .SWAP_BYTES (1'b0)
  ) u_data (
    .beat_valid (rd_valid),
    .data       (rd_data)
  );
endmodule

// File: rtl/rvb_reset_branch_slave_sva.sv
module rvb_reset_branch_slave_sva #(
  parameter int          DATA_W      = 32,
  parameter logic [31:0] BRANCH_WORD = 32'h4BFF_7FE4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              addr_ack,
  input logic              wr_done,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic [2:0]        rd_tag,
  input logic              rd_done,
  input logic              accept_evt,
  input logic              addr_hit
);
  assert_ack_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    addr_ack |=> !addr_ack);

  assert_ack_after_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> addr_ack);

  assert_accept_in_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |-> addr_hit);

  assert_beat_constant_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_data == BRANCH_WORD[DATA_W-1:0]));

  assert_done_on_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> rd_valid);

  assert_tag_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_done) |=> (rd_valid && (rd_tag == $past(rd_tag) + 3'd1)));

  assert_write_with_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |-> (addr_ack && !rd_valid));

  assert_no_ack_in_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !addr_ack);
endmodule

bind rvb_reset_branch_slave rvb_reset_branch_slave_sva #(
  .DATA_W      (DATA_W),
  .BRANCH_WORD (BRANCH_WORD)
) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .addr_ack   (addr_ack),
  .wr_done    (wr_done),
  .rd_valid   (rd_valid),
  .rd_data    (rd_data),
  .rd_tag     (rd_tag),
  .rd_done    (rd_done),
  .accept_evt (accept_evt),
  .addr_hit   (addr_hit)
);

// File: tb/rvb_reset_branch_slave_test.sv
`timescale 1ns/1ps
module rvb_reset_branch_slave_test;

  localparam logic [31:0] BRANCH = 32'h4BFF_7FE4;

  typedef struct {
    logic [2:0] tag;
    logic       last;
    string      req;
  } beat_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_rnw = 1'b1;
  logic [1:0]  req_size = 2'b00;
  logic        addr_ack, wr_done, rd_valid, rd_done;
  logic [31:0] rd_data;
  logic [2:0]  rd_tag;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;
  beat_t sb[$];

  always #4 clk = ~clk;

  rvb_reset_branch_slave uut (
    .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_addr (req_addr),
    .req_rnw (req_rnw), .req_size (req_size), .addr_ack (addr_ack),
    .wr_done (wr_done), .rd_valid (rd_valid), .rd_data (rd_data),
    .rd_tag (rd_tag), .rd_done (rd_done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // expected beat count and tag, restated from the size codes
  function automatic int beats_of(input logic [1:0] sz);
    if (sz == 2'b01) return 4;
    if (sz == 2'b10) return 8;
    return 1;
  endfunction

  function automatic logic [2:0] tag_of(input logic [1:0] sz, input logic [31:0] a, input int k);
    if (sz == 2'b01 || sz == 2'b10) return 3'(k);
    return a[4:2];
  endfunction

  // monitor: pops the scoreboard on every beat
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R2", "beat with none expected", 32'(rd_tag), 32'hx);
      end else begin
        beat_t e;
        e = sb.pop_front();
        chk(rd_data == BRANCH, "R4", {e.req, " data"}, rd_data, BRANCH);
        chk(rd_tag == e.tag, e.req, "tag", 32'(rd_tag), 32'(e.tag));
        chk(rd_done == e.last, "R8", {e.req, " done"}, 32'(rd_done), 32'(e.last));
      end
    end
  end

  task automatic do_read(input logic [31:0] a, input logic [1:0] sz, input string req);
    int n;
    n = beats_of(sz);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_rnw = 1'b1; req_size = sz;
    @(negedge clk);
    chk(addr_ack == 1'b1, "R3", {req, " ack"}, 32'(addr_ack), 32'd1);
    chk(rd_valid == 1'b0, "R11", {req, " no beat with ack"}, 32'(rd_valid), 32'd0);
    req_valid = 1'b0;
    for (int k = 0; k < n; k++) begin
      beat_t e;
      e.tag = tag_of(sz, a, k); e.last = (k == n - 1); e.req = req;
      sb.push_back(e);
    end
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk(rd_valid == 1'b1, "R11", {req, " consecutive beat"}, 32'(rd_valid), 32'd1);
    end
    @(negedge clk);
    chk(rd_valid == 1'b0 && sb.size() == 0, "R8", {req, " ended"}, 32'(sb.size()), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(addr_ack == 1'b0, "R1", "addr_ack in reset", 32'(addr_ack), 32'd0);
    chk(rd_valid == 1'b0 && rd_done == 1'b0, "R1", "rd flags in reset", 32'({rd_valid, rd_done}), 32'd0);
    chk(rd_data == 32'd0, "R1", "rd_data in reset", rd_data, 32'd0);
    chk(wr_done == 1'b0 && rd_tag == 3'd0, "R1", "wr_done/tag in reset", 32'({wr_done, rd_tag}), 32'd0);
    rst_n = 1'b1;

    do_read(32'hFFFF_FFFC, 2'b00, "R5");
    do_read(32'hFFFF_FFF0, 2'b01, "R6");
    do_read(32'hFFFF_FFE0, 2'b10, "R7");
    do_read(32'hFFFF_FFFC, 2'b01, "R6");
    do_read(32'hFFFF_FF08, 2'b11, "R7");
    do_read(32'hFFFF_FF00, 2'b00, "R5");

    // R2: outside the window
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'hFFFF_FEFC; req_rnw = 1'b1; req_size = 2'b01;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(addr_ack == 1'b0, "R2", "ack below window", 32'(addr_ack), 32'd0);
    end
    req_addr = 32'h0000_0000;
    @(negedge clk);
    chk(addr_ack == 1'b0, "R2", "ack at zero", 32'(addr_ack), 32'd0);
    req_valid = 1'b0;

    // R9: write is acknowledged without effect
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'hFFFF_FFFC; req_rnw = 1'b0; req_size = 2'b00;
    @(negedge clk);
    chk(addr_ack == 1'b1 && wr_done == 1'b1, "R9", "write ack", 32'({addr_ack, wr_done}), 32'd3);
    req_valid = 1'b0; req_rnw = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(rd_valid == 1'b0 && wr_done == 1'b0, "R9", "no beat after write", 32'({rd_valid, wr_done}), 32'd0);
    end
    do_read(32'hFFFF_FFFC, 2'b00, "R9");

    // R10: request during a data phase is ignored
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'hFFFF_FFE0; req_rnw = 1'b1; req_size = 2'b10;
    @(negedge clk);
    chk(addr_ack == 1'b1, "R3", "R10 line ack", 32'(addr_ack), 32'd1);
    req_valid = 1'b0;
    for (int k = 0; k < 8; k++) begin
      beat_t e;
      e.tag = 3'(k); e.last = (k == 7); e.req = "R10";
      sb.push_back(e);
    end
    @(negedge clk);
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'hFFFF_FFFC; req_size = 2'b00;
    @(negedge clk);
    chk(addr_ack == 1'b0, "R10", "ack during data phase", 32'(addr_ack), 32'd0);
    req_valid = 1'b0;
    repeat (7) @(negedge clk);
    chk(sb.size() == 0 && addr_ack == 1'b0, "R10", "line finished, no late ack", 32'(sb.size()), 32'd0);

    do_read(32'hFFFF_FFE4, 2'b10, "R7");

    finished = 1'b1;
  end

  initial begin
    fork
      begin wait (finished); end
      begin
        repeat (20000) @(posedge clk);
        compared++; mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule